// File: doc/BRIEF.md
# Threshold-Gated Playback FIFO Channel

This block is one buffer channel on the peripheral side of an audio path. A DMA engine writes words into it one at a time, and a downstream serial consumer takes them out over a valid/ready handshake. Each word that leaves the buffer toward the consumer raises a one-cycle pulse on `word_pulse`. The DMA side counts these pulses to track free space, so it needs no level or request signal from the channel.

In playback direction the channel holds its output until a programmed number of words has collected. It then streams on demand until the buffer runs dry, and after that it waits for the threshold again. In capture direction there is no threshold: any stored word is offered at once. The capacity of the channel is its own configured allocation, which may be smaller than the physical storage. A full buffer drops writes and raises a sticky overrun flag. A demand that finds the buffer empty while the stream is running raises a sticky underrun flag. A synchronous channel clear returns the channel to its idle state.

Top module: `pfc_chan`

## Requirements
- R1: In playback direction (`cfg_dir`=0), `dn_valid` stays low until `occupancy` reaches the effective threshold. For example, with a threshold of 16, a first burst of 8 words does not open the output and a second burst of 8 does.
- R2: Once the playback output has opened, it stays open while `occupancy` is above zero, even below the threshold. When the buffer is empty, the gate re-arms, and later words wait for the threshold again.
- R3: In capture direction (`cfg_dir`=1), `dn_valid` is high whenever `occupancy` is nonzero, whatever the threshold.
- R4: `word_pulse` is high in exactly those cycles where `dn_valid` and `dn_ready` are both high. Each such cycle removes one word.
- R5: Words leave on `dn_data` in the order they were written.
- R6: A `cfg_thresh` of 0 acts as 1. A `cfg_thresh` above the effective capacity acts as the effective capacity.
- R7: The channel's capacity is `cfg_depth`. A value of 0, or a value above DEPTH (32 by default), gives DEPTH. `occupancy` never exceeds the capacity.
- R8: A write while `occupancy` equals the capacity is discarded, and it sets `overrun`, which stays high until a clear or reset.
- R9: `dn_ready` high while the buffer is empty and the stream is running sets `underrun`, which stays high until a clear or reset. Capture direction is always running. Playback is running when its gate is open.
- R10: `chan_clr` high for one cycle empties the buffer, closes the gate and clears both flags.
- R11: After reset, `occupancy` is 0, `dn_valid` is low, and `overrun` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_clr | input | 1 | Synchronous channel clear |
| cfg_dir | input | 1 | 0 = playback (threshold-gated), 1 = capture |
| cfg_depth | input | 7 | Capacity allocation in words |
| cfg_thresh | input | 7 | Playback start threshold in words |
| wr_en | input | 1 | DMA word write strobe |
| wr_data | input | 16 | DMA write word |
| dn_valid | output | 1 | Word offered to the consumer |
| dn_ready | input | 1 | Consumer accepts or demands a word |
| dn_data | output | 16 | Word toward the consumer |
| word_pulse | output | 1 | One pulse per word removed |
| occupancy | output | 6 | Words currently held |
| overrun | output | 1 | Sticky: a write was dropped |
| underrun | output | 1 | Sticky: demand found the buffer empty while running |

## Verification
A counter that is off by one shows up in `occupancy` on the cycle after the faulty update. It also moves the cycle in which `dn_valid` rises, which gives the consumer a word too early or too late in the threshold test. A read pointer that skips a word puts a wrong value on `dn_data` on the very next handshake. A gate flag that fails to clear or re-arm is seen on the first short write after a drain, where `dn_valid` must stay low. Flag faults are seen one cycle after the write or demand that should have set them.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic {
    DIR_PLAY = 1'b0,
    DIR_CAPT = 1'b1
  } dir_e;
endpackage

// File: rtl/pfc_store.sv
module pfc_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_i) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_d = ptr_inc(rd_ptr_q);
      cnt_d = cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !clr_i) mem[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem[rd_ptr_q];
  assign cnt_o   = cnt_q;

  // R4
  pop_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/pfc_gate.sv
module pfc_gate
  import pfc_pkg::*;
#(
  parameter int CW    = 6,
  parameter int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  dir_e             dir_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [CFG_W-1:0] thr_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             underrun_evt_o
);
  logic live_q, live_d;
  logic empty, thr_met;

  assign empty   = (cnt_i == '0);
  assign thr_met = (CFG_W'(cnt_i) >= thr_i);

  always_comb begin
    live_d = live_q;
    if (clr_i || empty)                       live_d = 1'b0;
    else if (dir_i == DIR_PLAY && thr_met)    live_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= live_d;
  end

  assign valid_o = !empty && (dir_i == DIR_CAPT || live_q || thr_met);
  assign underrun_evt_o = ready_i && empty && (dir_i == DIR_CAPT || live_q);

  // R2
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live_q) |-> ($past(cnt_i) == '0 || $past(clr_i)));

  // R1
  open_at_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_o) && dir_i == DIR_PLAY) |-> (CFG_W'(cnt_i) >= thr_i));
endmodule

// File: rtl/pfc_chan.sv
module pfc_chan
  import pfc_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DEPTH    = 32,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = AW + 1,
  localparam int CFG_W   = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_clr,
  input  logic             cfg_dir,
  input  logic [CFG_W-1:0] cfg_depth,
  input  logic [CFG_W-1:0] cfg_thresh,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [DW-1:0]    dn_data,
  output logic             word_pulse,
  output logic [CW-1:0]    occupancy,
  output logic             overrun,
  output logic             underrun
);
  logic [CFG_W-1:0] depth_eff, thr_eff;
  logic             full, push, pop, urun_evt;
  logic             ovr_q, ovr_d, urn_q, urn_d;
  dir_e             dir;

  assign dir       = dir_e'(cfg_dir);
  assign depth_eff = (cfg_depth == '0 || cfg_depth > CFG_W'(DEPTH)) ? CFG_W'(DEPTH) : cfg_depth;
  assign thr_eff   = (cfg_thresh == '0) ? CFG_W'(1) :
                     (cfg_thresh > depth_eff) ? depth_eff : cfg_thresh;
  assign full      = (CFG_W'(occupancy) >= depth_eff);
  assign push      = wr_en && !full;
  assign pop       = dn_valid && dn_ready;

  pfc_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(chan_clr), .push_i(push), .pop_i(pop),
    .wdata_i(wr_data), .rdata_o(dn_data), .cnt_o(occupancy)
  );

  pfc_gate #(.CW(CW), .CFG_W(CFG_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .clr_i(chan_clr), .dir_i(dir), .cnt_i(occupancy),
    .thr_i(thr_eff), .ready_i(dn_ready), .valid_o(dn_valid), .underrun_evt_o(urun_evt)
  );

  always_comb begin
    ovr_d = ovr_q;
    urn_d = urn_q;
    if (chan_clr) begin
      ovr_d = 1'b0;
      urn_d = 1'b0;
    end else begin
      if (wr_en && full) ovr_d = 1'b1;
      if (urun_evt)      urn_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      urn_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      urn_q <= urn_d;
    end
  end

  assign word_pulse = pop;
  assign overrun    = ovr_q;
  assign underrun   = urn_q;

  // R8
  drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !chan_clr) |=> (overrun && occupancy <= $past(occupancy)));

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !chan_clr) |=> underrun);

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clr |=> (occupancy == '0 && !overrun && !underrun && !dn_valid));
endmodule

// File: tb/sim_pfc_chan.sv
module sim_pfc_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chan_clr, cfg_dir, wr_en, dn_ready;
  logic [6:0]  cfg_depth, cfg_thresh;
  logic [15:0] wr_data;
  logic        dn_valid, word_pulse, overrun, underrun;
  logic [15:0] dn_data;
  logic [5:0]  occupancy;
  int          n_chk = 0;
  int          n_bad = 0;
  int          rd_exp;

  always #10 clk = ~clk;

  pfc_chan u0 (
    .clk(clk), .rst_n(rst_n), .chan_clr(chan_clr), .cfg_dir(cfg_dir),
    .cfg_depth(cfg_depth), .cfg_thresh(cfg_thresh), .wr_en(wr_en), .wr_data(wr_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data), .word_pulse(word_pulse),
    .occupancy(occupancy), .overrun(overrun), .underrun(underrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic dir, input int depth, input int thr);
    cfg_dir = dir; cfg_depth = 7'(depth); cfg_thresh = 7'(thr);
    chan_clr = 1'b1;
    @(negedge clk);
    chan_clr = 1'b0;
  endtask

  task automatic push_words(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = 16'(base + i);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    dn_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      chk({req, " valid"}, dn_valid, 1);
      chk("R4 pulse on pop", word_pulse, 1);
      chk("R5 order", dn_data, rd_exp);
      rd_exp++;
      @(negedge clk);
    end
    dn_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R11 occupancy", occupancy, 0);
    chk("R11 valid", dn_valid, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 underrun", underrun, 0);
  endtask

  task automatic t_playback;
    setup(1'b0, 32, 16);
    rd_exp = 100;
    push_words(8, 100);
    chk("R1 after burst one occ", occupancy, 8);
    chk("R1 gated after burst one", dn_valid, 0);
    dn_ready = 1'b1; #1;
    chk("R4 no pulse while gated", word_pulse, 0);
    @(negedge clk);
    dn_ready = 1'b0;
    chk("R9 no underrun while armed", underrun, 0);
    push_words(8, 108);
    chk("R1 open after burst two", dn_valid, 1);
    drain(16, "R1");
    chk("R2 empty", occupancy, 0);
    chk("R2 valid low when empty", dn_valid, 0);
    @(negedge clk);
    push_words(5, 116);
    chk("R2 re-armed gate", dn_valid, 0);
    push_words(11, 121);
    drain(14, "R2");
    chk("R2 below thr occ", occupancy, 2);
    chk("R2 stays open below thr", dn_valid, 1);
    chk("R9 no underrun yet", underrun, 0);
    dn_ready = 1'b1;
    chk("R5 order tail", dn_data, rd_exp);
    repeat (3) @(negedge clk);
    dn_ready = 1'b0;
    chk("R9 playback underrun", underrun, 1);
  endtask

  task automatic t_capture;
    setup(1'b1, 32, 16);
    chk("R10 underrun cleared", underrun, 0);
    push_words(1, 500);
    #1;
    chk("R3 capture valid at once", dn_valid, 1);
    rd_exp = 500;
    drain(1, "R3");
    chk("R3 empty valid", dn_valid, 0);
    chk("R9 no underrun idle", underrun, 0);
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    chk("R9 capture underrun", underrun, 1);
  endtask

  task automatic t_thresh_clamp;
    setup(1'b0, 32, 0);
    push_words(1, 7);
    chk("R6 thr zero acts as one", dn_valid, 1);
    setup(1'b0, 8, 40);
    push_words(7, 0);
    chk("R6 thr above depth gated", dn_valid, 0);
    push_words(1, 7);
    chk("R6 thr clamped to depth", dn_valid, 1);
  endtask

  task automatic t_depth;
    setup(1'b0, 4, 16);
    push_words(6, 200);
    chk("R7 capacity 4", occupancy, 4);
    chk("R8 overrun set", overrun, 1);
    rd_exp = 200;
    drain(4, "R8");
    chk("R8 dropped words absent", occupancy, 0);
    chk("R8 overrun sticky", overrun, 1);
    setup(1'b0, 0, 16);
    chk("R10 overrun cleared", overrun, 0);
    push_words(33, 300);
    chk("R7 depth zero gives 32", occupancy, 32);
    chk("R8 overrun at 32", overrun, 1);
    setup(1'b0, 100, 16);
    push_words(33, 300);
    chk("R7 depth above max gives 32", occupancy, 32);
    chk_clear();
  endtask

  task automatic chk_clear;
    chan_clr = 1'b1;
    @(negedge clk);
    chan_clr = 1'b0;
    chk("R10 occupancy", occupancy, 0);
    chk("R10 overrun", overrun, 0);
    chk("R10 valid", dn_valid, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chan_clr = 1'b0; cfg_dir = 1'b0; wr_en = 1'b0; dn_ready = 1'b0;
    cfg_depth = 7'd32; cfg_thresh = 7'd16; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_playback();
    t_capture();
    t_thresh_clamp();
    t_depth();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule